// File: doc/BRIEF.md
# USB Serial Receive Byte Engine

This block is the receive half of the digital core of a USB 2.0 transceiver. It accepts a recovered line bit together with a single-ended-zero flag. A one-clock strobe marks each recovered bit, and the clock runs much faster than the bit rate. The block undoes NRZI coding and hunts for the packet preamble. It then strips stuffed zeros, packs the data bits least significant bit first into a holding register, and detects the end-of-packet condition.

Towards the link layer it offers a byte interface. `rx_active` spans the whole packet. `rx_valid` pulses for exactly one clock each time the holding register is filled, and the link must capture `rx_data` at the next rising edge. `rx_error` flags a bit-stuffing violation, and the packet is then aborted. Because stuffed bits take line time without adding data, a byte time can pass with no `rx_valid` pulse. Clock recovery, CRC checking and PID checking belong to other blocks.

Top module: `usb_rx_engine`

## Requirements
- R1: Line decoding is NRZI. On a strobe, a line level equal to the previous strobed level decodes as 1 and a change decodes as 0. The reference level after reset and after every single-ended-zero strobe is the idle J level (`line_level` = 1).
- R2: While idle, `rx_active` rises in the clock after the strobe that carries a decoded 1 immediately preceded by at least SYNC_ZEROS (default 5) decoded 0s. Fewer zeros start no packet. The first data bit is the next decoded bit.
- R3: Data bits are packed least significant bit first. `rx_valid` is high for exactly one clock, the clock after the strobe that delivers the eighth data bit. `rx_data` changes only in that clock and holds its value until the next byte.
- R4: A decoded 0 that follows six consecutive decoded 1s is discarded. The final 1 of the preamble counts towards those six. Such a bit lengthens the byte it falls in by one strobe and produces no `rx_valid`.
- R5: A seventh consecutive decoded 1 is a stuffing error. `rx_error` is high for one clock, the clock after that strobe, while `rx_active` is still high. `rx_active` falls in the following clock. No `rx_valid` occurs until a new packet starts after an end of packet.
- R6: End of packet is two consecutive single-ended-zero strobes. `rx_active` falls in the clock after the second one. A partly assembled byte is discarded without an `rx_valid` pulse.
- R7: After an end of packet, including one that closes an aborted packet, the receiver hunts for a new preamble. Single-ended-zero strobes while hunting start nothing.
- R8: `rx_valid` and `rx_error` are only ever high while `rx_active` is high.
- R9: In reset, `rx_active`, `rx_valid`, `rx_error` and `rx_data` are all 0.
- R10: `line_level` and `line_se0` are ignored in clocks where `bit_strobe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte-interface clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_strobe | input | 1 | One-clock strobe marking a recovered bit |
| line_level | input | 1 | Recovered differential level, 1 = J |
| line_se0 | input | 1 | Both data lines low for this bit |
| rx_data | output | DATA_W | Receive holding register |
| rx_active | output | 1 | Packet in progress |
| rx_valid | output | 1 | Holding register filled this clock |
| rx_error | output | 1 | Bit-stuffing violation |

## Verification
Each fault in internal state shows at the ports within one byte of line time. A wrong NRZI reference level or a mis-seeded stuffing counter changes the value of the first byte, or moves the drop of a stuffed bit by a position. That shows up as a byte mismatch or as a strobe spacing between `rx_valid` pulses that is 8 where 9 is expected, or 9 where 8 is expected. A packer count that is not cleared at a preamble or at an end of packet yields a spurious or shifted byte in the next packet. A stuck state register shows up as an `rx_active` edge that comes one clock late or never comes. The bench measures how many clocks separate every `rx_valid`, `rx_error` and `rx_active` edge from the strobe that caused it.

// File: rtl/usb_rx_pkg.sv
package usb_rx_pkg;
   typedef enum logic [1:0] {
      ST_HUNT  = 2'd0,
      ST_DATA  = 2'd1,
      ST_DRAIN = 2'd2
   } rx_state_e;
endpackage

// File: rtl/usb_rx_nrzi.sv
module usb_rx_nrzi #(
   parameter int EOP_SE0_BITS = 2,
   parameter bit J_LEVEL      = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic strobe,
   input  logic line,
   input  logic se0,
   output logic dec_vld,
   output logic dec_bit,
   output logic eop_hit
);
   logic prev_q;

   // R1: reference level tracks the last strobed level, J after SE0
   always_ff @(posedge clk) begin
      if (rst)
         prev_q <= J_LEVEL;
      else if (strobe)
         prev_q <= se0 ? J_LEVEL : line;
   end

   assign dec_vld = strobe & ~se0;
   assign dec_bit = ~(line ^ prev_q);

   generate
      if (EOP_SE0_BITS == 1) begin : g_eop_single
         assign eop_hit = strobe & se0;
      end else begin : g_eop_count
         localparam int CW = $clog2(EOP_SE0_BITS + 1);
         localparam logic [CW-1:0] LAST = CW'(EOP_SE0_BITS - 1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (rst)
               cnt_q <= '0;
            else if (strobe) begin
               if (!se0 || cnt_q == LAST)
                  cnt_q <= '0;
               else
                  cnt_q <= cnt_q + CW'(1);
            end
         end
         assign eop_hit = strobe & se0 & (cnt_q == LAST);
      end
   endgenerate

   // R10: without a strobe nothing is decoded and no EOP is seen
   a_r10_no_strobe_quiet: assert property (@(posedge clk) disable iff (rst)
      !strobe |-> !dec_vld && !eop_hit);
endmodule

// File: rtl/usb_rx_sync_hunt.sv
module usb_rx_sync_hunt #(
   parameter int SYNC_ZEROS = 5
) (
   input  logic clk,
   input  logic rst,
   input  logic dec_vld,
   input  logic dec_bit,
   input  logic flush,
   output logic hit
);
   logic [SYNC_ZEROS-1:0] hist_q;

   generate
      if (SYNC_ZEROS == 1) begin : g_hist_one
         always_ff @(posedge clk) begin
            if (rst || flush)
               hist_q <= '1;
            else if (dec_vld)
               hist_q <= dec_bit;
         end
      end else begin : g_hist_shift
         always_ff @(posedge clk) begin
            if (rst || flush)
               hist_q <= '1;
            else if (dec_vld)
               hist_q <= {hist_q[SYNC_ZEROS-2:0], dec_bit};
         end
      end
   endgenerate

   // R2: a decoded 1 right after SYNC_ZEROS decoded 0s
   assign hit = dec_vld & dec_bit & (hist_q == '0);

   a_r2_hit_needs_bit: assert property (@(posedge clk) disable iff (rst)
      hit |-> dec_vld && !flush);
endmodule

// File: rtl/usb_rx_destuff.sv
module usb_rx_destuff #(
   parameter int STUFF_LIMIT = 6
) (
   input  logic clk,
   input  logic rst,
   input  logic dec_vld,
   input  logic dec_bit,
   input  logic seed,
   input  logic flush,
   output logic bit_keep,
   output logic stuff_err
);
   localparam int OW = $clog2(STUFF_LIMIT + 1);
   localparam logic [OW-1:0] LIM = OW'(STUFF_LIMIT);

   logic [OW-1:0] ones_q;
   logic          at_lim;

   assign at_lim    = (ones_q == LIM);
   assign bit_keep  = dec_vld & ~at_lim;
   assign stuff_err = dec_vld & dec_bit & at_lim;

   always_ff @(posedge clk) begin
      if (rst || flush)
         ones_q <= '0;
      else if (seed)
         ones_q <= OW'(1);                 // R4: preamble's last 1 counts
      else if (dec_vld) begin
         if (dec_bit && !at_lim)
            ones_q <= ones_q + OW'(1);
         else
            ones_q <= '0;
      end
   end

   // R4: after a dropped bit the run restarts from zero
   a_r4_drop_restarts: assert property (@(posedge clk) disable iff (rst)
      (dec_vld && !dec_bit && at_lim && !seed && !flush) |=> !at_lim);
endmodule

// File: rtl/usb_rx_byte_pack.sv
module usb_rx_byte_pack #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bit_vld,
   input  logic              bit_in,
   input  logic              clear,
   output logic [DATA_W-1:0] byte_q,
   output logic              load_q
);
   localparam int CW = $clog2(DATA_W);
   localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

   logic [DATA_W-1:0] sh_q;
   logic [CW-1:0]     cnt_q;
   logic [DATA_W-1:0] sh_next;

   assign sh_next = {bit_in, sh_q[DATA_W-1:1]};

   always_ff @(posedge clk) begin
      if (rst) begin
         sh_q   <= '0;
         cnt_q  <= '0;
         byte_q <= '0;
         load_q <= 1'b0;
      end else begin
         load_q <= 1'b0;
         if (clear)
            cnt_q <= '0;                   // R6: partial byte dropped
         else if (bit_vld) begin
            sh_q <= sh_next;
            if (cnt_q == LAST) begin
               byte_q <= sh_next;          // R3: LSB first
               load_q <= 1'b1;
               cnt_q  <= '0;
            end else
               cnt_q <= cnt_q + CW'(1);
         end
      end
   end

   a_r6_clear_no_load: assert property (@(posedge clk) disable iff (rst)
      clear |=> !load_q);
   a_r3_single_load: assert property (@(posedge clk) disable iff (rst)
      load_q |=> !load_q);
endmodule

// File: rtl/usb_rx_engine.sv
module usb_rx_engine
   import usb_rx_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int SYNC_ZEROS   = 5,
   parameter int STUFF_LIMIT  = 6,
   parameter int EOP_SE0_BITS = 2,
   parameter bit J_LEVEL      = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bit_strobe,
   input  logic              line_level,
   input  logic              line_se0,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_active,
   output logic              rx_valid,
   output logic              rx_error
);
   generate
      if (DATA_W < 2)        begin : g_bad_w   $error("DATA_W must be at least 2");       end
      if (SYNC_ZEROS < 1)    begin : g_bad_s   $error("SYNC_ZEROS must be at least 1");   end
      if (STUFF_LIMIT < 1)   begin : g_bad_l   $error("STUFF_LIMIT must be at least 1");  end
      if (EOP_SE0_BITS < 1)  begin : g_bad_e   $error("EOP_SE0_BITS must be at least 1"); end
   endgenerate

   logic dec_vld, dec_bit, eop_hit, hunt_hit;
   logic bit_keep, stuff_err;
   logic sync_go, in_data, stuff_abort, pack_clear;
   rx_state_e state_q;
   logic act_q, err_q;

   usb_rx_nrzi #(.EOP_SE0_BITS(EOP_SE0_BITS), .J_LEVEL(J_LEVEL)) u_nrzi (
      .clk(clk), .rst(rst), .strobe(bit_strobe), .line(line_level), .se0(line_se0),
      .dec_vld(dec_vld), .dec_bit(dec_bit), .eop_hit(eop_hit));

   usb_rx_sync_hunt #(.SYNC_ZEROS(SYNC_ZEROS)) u_hunt (
      .clk(clk), .rst(rst), .dec_vld(dec_vld), .dec_bit(dec_bit),
      .flush(bit_strobe & line_se0), .hit(hunt_hit));

   assign in_data     = (state_q == ST_DATA);
   assign sync_go     = (state_q == ST_HUNT) & hunt_hit;
   assign stuff_abort = in_data & stuff_err;
   assign pack_clear  = sync_go | (in_data & eop_hit) | stuff_abort;

   usb_rx_destuff #(.STUFF_LIMIT(STUFF_LIMIT)) u_destuff (
      .clk(clk), .rst(rst), .dec_vld(dec_vld), .dec_bit(dec_bit),
      .seed(sync_go), .flush(eop_hit), .bit_keep(bit_keep), .stuff_err(stuff_err));

   usb_rx_byte_pack #(.DATA_W(DATA_W)) u_pack (
      .clk(clk), .rst(rst), .bit_vld(in_data & bit_keep), .bit_in(dec_bit),
      .clear(pack_clear), .byte_q(rx_data), .load_q(rx_valid));

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_HUNT;
         act_q   <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         err_q <= stuff_abort;
         unique case (state_q)
            ST_HUNT: if (sync_go) begin
               state_q <= ST_DATA;
               act_q   <= 1'b1;
            end
            ST_DATA: if (eop_hit) begin
               state_q <= ST_HUNT;
               act_q   <= 1'b0;
            end else if (stuff_abort)
               state_q <= ST_DRAIN;
            ST_DRAIN: begin
               act_q <= 1'b0;              // R5: drop one clock after the error
               if (eop_hit)
                  state_q <= ST_HUNT;
            end
            default: state_q <= ST_HUNT;
         endcase
      end
   end

   assign rx_active = act_q;
   assign rx_error  = err_q;

   a_r2_rise_on_bit: assert property (@(posedge clk) disable iff (rst)
      $rose(rx_active) |-> $past(bit_strobe && !line_se0));
   a_r6_fall_cause: assert property (@(posedge clk) disable iff (rst)
      $fell(rx_active) |-> ($past(bit_strobe && line_se0) || $past(rx_error)));
   a_r3_valid_after_bit: assert property (@(posedge clk) disable iff (rst)
      $rose(rx_valid) |-> $past(bit_strobe));
   a_r8_valid_in_active: assert property (@(posedge clk) disable iff (rst)
      rx_valid |-> rx_active);
   a_r8_error_in_active: assert property (@(posedge clk) disable iff (rst)
      rx_error |-> rx_active);
   a_r3_data_hold: assert property (@(posedge clk) disable iff (rst)
      !$stable(rx_data) |-> rx_valid);
   a_r5_abort: assert property (@(posedge clk) disable iff (rst)
      rx_error |=> !rx_active && !rx_valid && !rx_error);
endmodule

// File: tb/test_usb_rx_engine.sv
module test_usb_rx_engine;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       bit_strobe = 1'b0;
   logic       line_level = 1'b1;
   logic       line_se0 = 1'b0;
   logic [7:0] rx_data;
   logic       rx_active, rx_valid, rx_error;

   always #4 clk = ~clk;

   usb_rx_engine i_usb_rx_engine (
      .clk(clk), .rst(rst), .bit_strobe(bit_strobe), .line_level(line_level),
      .line_se0(line_se0), .rx_data(rx_data), .rx_active(rx_active),
      .rx_valid(rx_valid), .rx_error(rx_error));

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // monitor state
   logic [7:0] got [0:63];
   int got_idx [0:63];
   int n_got = 0, n_err = 0, n_rise = 0, n_fall = 0;
   int strobes = 0, since = 0, rise_lag = -1, fall_lag = -1, err_lag = -1;
   logic act_prev = 1'b0;

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // sample 2 ns after each rising edge
   always @(posedge clk) begin
      #2;
      if (!rst) begin
         since = bit_strobe ? 0 : since + 1;
         if (bit_strobe) strobes++;
         if (rx_active && !act_prev) begin n_rise++; rise_lag = since; end
         if (!rx_active && act_prev) begin n_fall++; fall_lag = since; end
         if (rx_valid) begin
            check("R3 valid lag after strobe", since, 0);
            check("R8 valid while active", int'(rx_active), 1);
            if (n_got < 64) begin got[n_got] = rx_data; got_idx[n_got] = strobes; end
            n_got++;
         end
         if (rx_error) begin
            n_err++; err_lag = since;
            check("R5 error while active", int'(rx_active), 1);
         end
         act_prev = rx_active;
      end
   end

   // ---- line driver ----
   logic lvl = 1'b1;
   int   ones = 0;

   task automatic send_lvl(input logic l, input logic s);
      @(negedge clk);
      bit_strobe = 1'b1; line_level = l; line_se0 = s;
      repeat (2) begin
         @(negedge clk);
         bit_strobe = 1'b0;                // R10: junk between strobes
         line_level = 1'($urandom);
         line_se0   = 1'($urandom);
      end
   endtask

   task automatic raw(input logic b);
      if (!b) lvl = ~lvl;
      send_lvl(lvl, 1'b0);
   endtask

   task automatic dbit(input logic b);
      raw(b);
      if (b) begin
         ones++;
         if (ones == 6) begin raw(1'b0); ones = 0; end
      end else ones = 0;
   endtask

   task automatic dbyte(input logic [7:0] x);
      for (int i = 0; i < 8; i++) dbit(x[i]);
   endtask

   task automatic sync(input int nz);
      lvl = 1'b1;
      repeat (nz) raw(1'b0);
      raw(1'b1);
      ones = 1;
   endtask

   task automatic eop();
      send_lvl(1'b0, 1'b1);
      send_lvl(1'b0, 1'b1);
      lvl = 1'b1;
      send_lvl(1'b1, 1'b0);
   endtask

   task automatic idle(input int n);
      lvl = 1'b1;
      repeat (n) send_lvl(1'b1, 1'b0);
   endtask

   // {first byte, second byte, strobes between their valid pulses}
   localparam logic [19:0] VEC [0:5] = '{
      {8'h00, 8'h00, 4'd8},
      {8'hA5, 8'h5A, 4'd8},
      {8'hFF, 8'hFF, 4'd9},
      {8'h7E, 8'hFF, 4'd9},
      {8'hFF, 8'h00, 4'd8},
      {8'h80, 8'h3F, 4'd9}
   };

   task automatic report();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         report();
      end
   end

   initial begin
      int base, e0, f0, r0;
      repeat (3) @(negedge clk);
      // R9 reset state
      check("R9 active in reset", int'(rx_active), 0);
      check("R9 valid in reset",  int'(rx_valid), 0);
      check("R9 error in reset",  int'(rx_error), 0);
      check("R9 data in reset",   int'(rx_data), 0);
      rst = 1'b0;
      idle(3);

      // table-driven packets: R1 decode, R3 packing, R4 stuffing, R6 end, R10 junk
      for (int v = 0; v < 6; v++) begin
         base = n_got; e0 = n_err; f0 = n_fall; r0 = n_rise;
         sync(7);
         check("R2 rise lag", rise_lag, 0);
         check("R2 one packet start", n_rise - r0, 1);
         dbyte(VEC[v][19:12]);
         dbyte(VEC[v][11:4]);
         eop();
         idle(2);
         check("R3 byte count", n_got - base, 2);
         check("R1 R3 first byte",  int'(got[base]),     int'(VEC[v][19:12]));
         check("R1 R3 second byte", int'(got[base + 1]), int'(VEC[v][11:4]));
         check("R4 strobe spacing", got_idx[base + 1] - got_idx[base], int'(VEC[v][3:0]));
         check("R6 single fall", n_fall - f0, 1);
         check("R6 fall lag", fall_lag, 0);
         check("R5 no error", n_err - e0, 0);
      end

      // R2 preamble too short, then exactly SYNC_ZEROS zeros
      r0 = n_rise;
      sync(4);
      idle(3);
      check("R2 short preamble ignored", n_rise - r0, 0);
      sync(5);
      check("R2 exact preamble starts", n_rise - r0, 1);
      check("R2 rise lag exact", rise_lag, 0);
      eop();
      idle(2);

      // R7 SE0 while hunting starts nothing
      r0 = n_rise;
      repeat (3) send_lvl(1'b0, 1'b1);
      idle(2);
      check("R7 se0 while hunting", n_rise - r0, 0);

      // R5 stuffing error: preamble 1 plus six more 1s
      base = n_got; e0 = n_err; f0 = n_fall; r0 = n_rise;
      sync(7);
      repeat (6) raw(1'b1);
      check("R5 error raised", n_err - e0, 1);
      check("R5 error lag", err_lag, 0);
      @(negedge clk);
      check("R5 aborted", n_fall - f0, 1);
      repeat (3) raw(1'b0);
      repeat (8) raw(1'b1);
      check("R5 no valid after abort", n_got - base, 0);
      check("R5 no restart in drain", n_rise - r0, 1);
      eop();
      idle(2);
      // R7 recovery after abort
      sync(7);
      dbyte(8'hC3);
      eop();
      idle(2);
      check("R7 byte after recovery", n_got - base, 1);
      check("R7 recovered value", int'(got[base]), 8'hC3);

      // R6 partial byte dropped
      base = n_got; f0 = n_fall;
      sync(7);
      dbyte(8'h3C);
      dbit(1'b1); dbit(1'b0); dbit(1'b1); dbit(1'b1);
      eop();
      idle(2);
      check("R6 partial dropped", n_got - base, 1);
      check("R6 full byte kept", int'(got[base]), 8'h3C);
      check("R6 fell once", n_fall - f0, 1);
      check("R3 data held", int'(rx_data), 8'h3C);

      done = 1'b1;
      report();
   end
endmodule